// File: doc/BRIEF.md
# Programmable-Polynomial CRC / Pseudo-Random Sequence Slice

This block is one slice of a linear-feedback shift engine. Each enabled clock it advances a stored value by one step. In CRC mode the incoming serial bit is folded into the feedback, and in pseudo-random mode the value runs freely. The generator polynomial sits in its own register, and the running value sits in an accumulator. Both are written at run time. A small selector picks which bit position acts as the top of the register, so the live length is anywhere from 1 to 8 bits. Bits above that position are always cleared.

The operation is chosen every cycle. CRC, free-running sequence, plain shift and hold can therefore be interleaved clock by clock. A seed input presets the accumulator.

Two slices combine into one register of up to 16 bits:
- The lower slice's top bit is passed into the upper slice's least significant bit.
- The upper slice's feedback decision is passed back to the lower slice, which uses it in place of its own.

Top module: `crc_prs_slice`

## Requirements
- R1: While reset is low, the accumulator and the polynomial register are cleared to zero. After reset, value_out reads 0, and a CRC step with serial_in = 1 leaves the value at 0.
- R2: With seed_we high, the next clock loads seed_in ANDed with the length mask. The length mask has ones in bit positions 0 to msb_sel. A seed load takes priority over a step requested in the same cycle.
- R3: In mode 2'b00 (CRC), with step_en high, one clock computes the next value as follows. The feedback is value[msb_sel] XOR serial_in. The next value is (value << 1), XORed with the polynomial when the feedback is 1, then masked.
- R4: In mode 2'b01 (pseudo-random), the step is the same as in R3, except that the feedback is value[msb_sel] alone.
- R5: Bits of value_out above msb_sel are zero after every seed load or step, including a step taken right after msb_sel has been reduced.
- R6: In pseudo-random mode without chaining, a zero value stays zero on every step.
- R7: If step_en is low, or the mode is 2'b11 (hold), the value does not change.
- R8: In mode 2'b10 (shift), with link_en low, the next value is ((value << 1) | serial_in), masked. The polynomial is not applied.
- R9: msb_out equals value[msb_sel]. fb_out equals value[msb_sel] XOR (serial_in when the mode is CRC). Both outputs are combinational.
- R10: When fb_ext_en is high, fb_in replaces the feedback. When link_en is high, link_in replaces the bit shifted into bit 0, in every stepping mode. A lower slice (msb_sel = 7, fb_ext_en high) paired with an upper slice (link_en high, link_in fed from the lower msb_out) steps as one register of 9 to 16 bits, with polynomial {upper, lower}.
- R11: poly_we loads poly_in on the clock edge. A step in the same cycle still uses the old polynomial, and the new one applies from the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Step mode: 00 CRC, 01 pseudo-random, 10 shift, 11 hold |
| step_en | input | 1 | Advance the value this cycle |
| serial_in | input | 1 | Serial data bit (CRC input, shift input) |
| msb_sel | input | SW | Index of the top bit, which sets the register length |
| poly_we | input | 1 | Load the polynomial register |
| poly_in | input | W | Polynomial value |
| seed_we | input | 1 | Preset the accumulator |
| seed_in | input | W | Seed value |
| fb_ext_en | input | 1 | Use fb_in as the feedback |
| fb_in | input | 1 | Feedback from the upper neighbour |
| link_en | input | 1 | Use link_in as the bit entering bit 0 |
| link_in | input | 1 | Top bit from the lower neighbour |
| value_out | output | W | Accumulator value |
| msb_out | output | 1 | Current top bit |
| fb_out | output | 1 | This slice's own feedback decision |

## Verification
The hardest case to reach is a chained pair whose upper slice has a 1-bit length (msb_sel = 0). Its single bit is then both the chain link receiver and the feedback source for all 9 bits. A fault in the link or feedback crossing only shows after the value has wrapped through that bit. The bench wires two instances together, seeds them, and sweeps the upper length over 8, 4 and 1 bits. It runs CRC, pseudo-random and shift sequences against a 16-bit bitwise model. Single-slice behaviour is covered by a sweep over every polynomial at every length.

// File: rtl/crc_prs_pkg.sv
package crc_prs_pkg;
  typedef enum logic [1:0] {
    STEP_CRC   = 2'b00,
    STEP_PRS   = 2'b01,
    STEP_SHIFT = 2'b10,
    STEP_HOLD  = 2'b11
  } step_mode_e;
endpackage

// File: rtl/crc_prs_lenmask.sv
module crc_prs_lenmask #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [SW-1:0] msb_sel,
  output logic [W-1:0]  len_mask
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign len_mask[gi] = (gi <= int'(msb_sel));
    end
  endgenerate
endmodule

// File: rtl/crc_prs_feedback.sv
module crc_prs_feedback import crc_prs_pkg::*; #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [W-1:0]  value,
  input  logic [SW-1:0] msb_sel,
  input  step_mode_e    mode,
  input  logic          serial_in,
  input  logic          fb_ext_en,
  input  logic          fb_in,
  output logic          top_bit,
  output logic          own_fb,
  output logic          eff_fb
);
  function automatic logic pick_top(input logic [W-1:0] v, input logic [SW-1:0] m);
    logic r;
    r = 1'b0;
    for (int i = 0; i < W; i++)
      if (i == int'(m)) r = v[i];
    return r;
  endfunction

  assign top_bit = pick_top(value, msb_sel);
  assign own_fb  = top_bit ^ ((mode == STEP_CRC) & serial_in);
  assign eff_fb  = fb_ext_en ? fb_in : own_fb;
endmodule

// File: rtl/crc_prs_next.sv
module crc_prs_next import crc_prs_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] poly,
  input  logic [W-1:0] len_mask,
  input  step_mode_e   mode,
  input  logic         eff_fb,
  input  logic         lsb_in,
  output logic [W-1:0] next_val
);
  function automatic logic [W-1:0] advance(
    input logic [W-1:0] v,
    input logic [W-1:0] p,
    input logic [W-1:0] m,
    input logic         plain_shift,
    input logic         fb,
    input logic         lsb
  );
    logic [W-1:0] s;
    s = {v[W-2:0], lsb};
    if (!plain_shift && fb) s = s ^ p;
    return s & m;
  endfunction

  assign next_val = advance(value, poly, len_mask, mode == STEP_SHIFT, eff_fb, lsb_in);
endmodule

// File: rtl/crc_prs_slice.sv
module crc_prs_slice import crc_prs_pkg::*; #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          step_en,
  input  logic          serial_in,
  input  logic [SW-1:0] msb_sel,
  input  logic          poly_we,
  input  logic [W-1:0]  poly_in,
  input  logic          seed_we,
  input  logic [W-1:0]  seed_in,
  input  logic          fb_ext_en,
  input  logic          fb_in,
  input  logic          link_en,
  input  logic          link_in,
  output logic [W-1:0]  value_out,
  output logic          msb_out,
  output logic          fb_out
);
  logic [W-1:0] value_q;
  logic [W-1:0] poly_q;
  logic [W-1:0] len_mask;
  logic [W-1:0] next_val;
  step_mode_e   mode_e;
  logic         top_bit;
  logic         own_fb;
  logic         eff_fb;
  logic         lsb_in;
  logic         seed_fire;
  logic         step_fire;

  assign mode_e    = step_mode_e'(mode);
  assign seed_fire = seed_we;
  assign step_fire = step_en && (mode_e != STEP_HOLD) && !seed_we;
  assign lsb_in    = link_en ? link_in : ((mode_e == STEP_SHIFT) & serial_in);

  crc_prs_lenmask #(.W(W), .SW(SW)) u_mask (
    .msb_sel  (msb_sel),
    .len_mask (len_mask)
  );

  crc_prs_feedback #(.W(W), .SW(SW)) u_fb (
    .value     (value_q),
    .msb_sel   (msb_sel),
    .mode      (mode_e),
    .serial_in (serial_in),
    .fb_ext_en (fb_ext_en),
    .fb_in     (fb_in),
    .top_bit   (top_bit),
    .own_fb    (own_fb),
    .eff_fb    (eff_fb)
  );

  crc_prs_next #(.W(W)) u_next (
    .value    (value_q),
    .poly     (poly_q),
    .len_mask (len_mask),
    .mode     (mode_e),
    .eff_fb   (eff_fb),
    .lsb_in   (lsb_in),
    .next_val (next_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      poly_q  <= '0;
    end else begin
      if (poly_we) poly_q <= poly_in;
      if (seed_fire)      value_q <= seed_in & len_mask;
      else if (step_fire) value_q <= next_val;
    end
  end

  assign value_out = value_q;
  assign msb_out   = top_bit;
  assign fb_out    = own_fb;
endmodule

// File: rtl/crc_prs_slice_chk.sv
module crc_prs_slice_chk #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          step_en,
  input logic          serial_in,
  input logic [SW-1:0] msb_sel,
  input logic          seed_we,
  input logic [W-1:0]  seed_in,
  input logic          fb_ext_en,
  input logic          link_en,
  input logic [W-1:0]  value_out,
  input logic          msb_out,
  input logic          fb_out
);
  function automatic logic [W-1:0] lmask(input logic [SW-1:0] m);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i <= int'(m));
    return r;
  endfunction

  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> value_out == '0);

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> value_out == ($past(seed_in) & lmask($past(msb_sel))));

  p_len_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_we || (step_en && mode != 2'b11)) |=>
      (value_out & ~lmask($past(msb_sel))) == '0);

  p_zero_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && step_en && mode == 2'b01 && !fb_ext_en && !link_en && value_out == '0)
      |=> value_out == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && (!step_en || mode == 2'b11)) |=> $stable(value_out));

  p_top_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msb_out == value_out[msb_sel]);

  p_fb_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_out == (msb_out ^ (mode == 2'b00 && serial_in)));
endmodule

bind crc_prs_slice crc_prs_slice_chk #(.W(W), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .step_en   (step_en),
  .serial_in (serial_in),
  .msb_sel   (msb_sel),
  .seed_we   (seed_we),
  .seed_in   (seed_in),
  .fb_ext_en (fb_ext_en),
  .link_en   (link_en),
  .value_out (value_out),
  .msb_out   (msb_out),
  .fb_out    (fb_out)
);

// File: tb/tb_crc_prs_slice.sv
`timescale 1ns/1ps
module tb_crc_prs_slice;
  localparam int W  = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]    mode = 2'b00;
  logic          step_en = 1'b0, serial_in = 1'b0, chain = 1'b0;
  logic [SW-1:0] lo_msb = '0, hi_msb = '0;
  logic          lo_pwe = 1'b0, hi_pwe = 1'b0, lo_swe = 1'b0, hi_swe = 1'b0;
  logic [W-1:0]  lo_poly = '0, hi_poly = '0, lo_seed = '0, hi_seed = '0;
  logic [W-1:0]  lo_val, hi_val;
  logic          lo_msbo, hi_msbo, lo_fb, hi_fb;

  crc_prs_slice #(.W(W), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step_en(step_en), .serial_in(serial_in),
    .msb_sel(lo_msb), .poly_we(lo_pwe), .poly_in(lo_poly), .seed_we(lo_swe),
    .seed_in(lo_seed), .fb_ext_en(chain), .fb_in(hi_fb), .link_en(1'b0),
    .link_in(1'b0), .value_out(lo_val), .msb_out(lo_msbo), .fb_out(lo_fb)
  );

  crc_prs_slice #(.W(W), .SW(SW)) dut_hi (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step_en(step_en), .serial_in(serial_in),
    .msb_sel(hi_msb), .poly_we(hi_pwe), .poly_in(hi_poly), .seed_we(hi_swe),
    .seed_in(hi_seed), .fb_ext_en(1'b0), .fb_in(1'b0), .link_en(chain),
    .link_in(lo_msbo), .value_out(hi_val), .msb_out(hi_msbo), .fb_out(hi_fb)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] mv, mpoly;
  int mtop;
  logic [15:0] rng = 16'hACE1;

  function automatic logic [15:0] ref_step(input logic [15:0] v, input logic [15:0] p,
                                           input int top, input logic [1:0] md, input logic s);
    logic f, below;
    logic [15:0] r;
    r = '0;
    if (md == 2'b11) return v;
    f = v[top] ^ ((md == 2'b00) ? s : 1'b0);
    for (int i = 0; i <= top; i++) begin
      below = (i == 0) ? ((md == 2'b10) ? s : 1'b0) : v[i-1];
      r[i] = below ^ ((md != 2'b10) && f && p[i]);
    end
    return r;
  endfunction

  function automatic logic [7:0] mask8(input int top);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i <= top);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic next_bit(output logic b);
    rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
    b = rng[0];
  endtask

  task automatic load_single(input logic [7:0] p, input logic [7:0] s, input int msb);
    chain = 1'b0; lo_pwe = 1'b1; lo_swe = 1'b1; lo_poly = p; lo_seed = s;
    lo_msb = msb[SW-1:0]; step_en = 1'b0;
    tick;
    lo_pwe = 1'b0; lo_swe = 1'b0;
    mv = {8'h00, s & mask8(msb)}; mpoly = {8'h00, p}; mtop = msb;
    chk("R2 seed load masked", {24'h0, lo_val}, {16'h0, mv});
  endtask

  task automatic step_single(input logic [1:0] md, input logic s, input logic en);
    string tag;
    mode = md; serial_in = s; step_en = en;
    #1;
    chk("R9 msb_out", {31'h0, lo_msbo}, {31'h0, mv[mtop]});
    chk("R9 fb_out", {31'h0, lo_fb}, {31'h0, mv[mtop] ^ (md == 2'b00 && s)});
    tick;
    if (en) mv = ref_step(mv, mpoly, mtop, md, s);
    if (!en)              tag = "R7 step_en low holds";
    else if (md == 2'b11) tag = "R7 hold mode";
    else if (md == 2'b10) tag = "R8 shift step / R5 length";
    else if (md == 2'b01) tag = "R4 prs step / R5 length";
    else                  tag = "R3 crc step / R5 length";
    chk(tag, {24'h0, lo_val}, {16'h0, mv});
    step_en = 1'b0;
  endtask

  task automatic load_chain(input logic [7:0] phi, input logic [7:0] plo,
                            input logic [7:0] shi, input logic [7:0] slo, input int mh);
    chain = 1'b1; step_en = 1'b0;
    lo_pwe = 1'b1; lo_swe = 1'b1; lo_poly = plo; lo_seed = slo; lo_msb = 3'd7;
    hi_pwe = 1'b1; hi_swe = 1'b1; hi_poly = phi; hi_seed = shi; hi_msb = mh[SW-1:0];
    tick;
    lo_pwe = 1'b0; lo_swe = 1'b0; hi_pwe = 1'b0; hi_swe = 1'b0;
    mv = {shi & mask8(mh), slo}; mpoly = {phi, plo}; mtop = 8 + mh;
    chk("R10 chained seed", {16'h0, hi_val, lo_val}, {16'h0, mv});
  endtask

  task automatic step_chain(input logic [1:0] md, input logic s);
    mode = md; serial_in = s; step_en = 1'b1;
    #1;
    chk("R10 upper feedback", {31'h0, hi_fb}, {31'h0, mv[mtop] ^ (md == 2'b00 && s)});
    tick;
    mv = ref_step(mv, mpoly, mtop, md, s);
    chk("R10 chained step", {16'h0, hi_val, lo_val}, {16'h0, mv});
    step_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) act=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] newp;
    repeat (3) @(negedge clk);
    chk("R1 reset clears value", {24'h0, lo_val}, 32'h0);
    chk("R1 reset clears upper value", {24'h0, hi_val}, 32'h0);
    rst_n = 1'b1;
    tick;
    chk("R1 value after reset", {24'h0, lo_val}, 32'h0);
    // R1: the polynomial is zero after reset, so a forced feedback step stays at zero
    mv = '0; mpoly = '0; mtop = 0;
    step_single(2'b00, 1'b1, 1'b1);
    chk("R1 reset polynomial is zero", {24'h0, lo_val}, 32'h0);

    // R3 R7: every polynomial at every length, CRC with hold cycles interleaved
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 256; p++) begin
        load_single(p[7:0], p[7:0] ^ 8'hA5, m);
        for (int k = 0; k < 12; k++) begin
          next_bit(b);
          step_single((k == 7) ? 2'b11 : 2'b00, b, (k % 5) != 3);
        end
      end

    // R4 free-running sequences
    for (int m = 0; m < 8; m++)
      for (int p = 1; p < 256; p += 11) begin
        load_single(p[7:0], 8'h5B ^ p[7:0], m);
        for (int k = 0; k < 10; k++) begin
          next_bit(b);
          step_single(2'b01, b, 1'b1);
        end
      end

    // R6 zero seed in sequence mode
    for (int m = 0; m < 8; m++) begin
      load_single(8'hB8, 8'h00, m);
      for (int k = 0; k < 12; k++) begin
        next_bit(b);
        step_single(2'b01, b, 1'b1);
      end
      chk("R6 zero seed stays zero", {24'h0, lo_val}, 32'h0);
    end

    // R8 plain shift at every length
    for (int m = 0; m < 8; m++) begin
      load_single(8'h1D, 8'h3C, m);
      for (int k = 0; k < 10; k++) begin
        next_bit(b);
        step_single(2'b10, b, 1'b1);
      end
    end

    // R3 R4 R8 alternating operation cycle by cycle
    load_single(8'h07, 8'h80, 7);
    for (int k = 0; k < 24; k++) begin
      next_bit(b);
      step_single((k % 3 == 0) ? 2'b00 : (k % 3 == 1) ? 2'b01 : 2'b10, b, 1'b1);
    end

    // R2 seed wins over a simultaneous step
    lo_swe = 1'b1; lo_seed = 8'h5C; lo_msb = 3'd7; mode = 2'b00; step_en = 1'b1; serial_in = 1'b1;
    tick;
    lo_swe = 1'b0; step_en = 1'b0;
    mv = 16'h005C; mtop = 7;
    chk("R2 seed priority over step", {24'h0, lo_val}, 32'h5C);

    // R11 polynomial written in the same cycle as a step
    newp = 8'h2F;
    serial_in = mv[mtop] ^ 1'b1; mode = 2'b00; step_en = 1'b1;
    lo_pwe = 1'b1; lo_poly = newp;
    tick;
    lo_pwe = 1'b0; step_en = 1'b0;
    mv = ref_step(mv, mpoly, mtop, 2'b00, mv[mtop] ^ 1'b1);
    chk("R11 same-cycle step uses old poly", {24'h0, lo_val}, {16'h0, mv});
    mpoly = {8'h00, newp};
    step_single(2'b00, mv[mtop] ^ 1'b1, 1'b1);
    chk("R11 new poly applies next step", {24'h0, lo_val}, {16'h0, mv});

    // R5 length reduced with wider content still stored
    load_single(8'h00, 8'hFF, 7);
    lo_msb = 3'd3; mtop = 3;
    step_single(2'b10, 1'b1, 1'b1);
    chk("R5 bits above reduced msb cleared", {24'h0, lo_val}, 32'h0F);

    // R10 chained pair with upper lengths 8, 4 and 1 bits
    for (int j = 0; j < 3; j++) begin
      int mh;
      mh = (j == 0) ? 7 : (j == 1) ? 3 : 0;
      load_chain(8'h10, 8'h21, 8'hC3, 8'h5A, mh);
      for (int k = 0; k < 30; k++) begin
        next_bit(b);
        step_chain(2'b00, b);
      end
      load_chain(8'hB4, 8'h00, 8'h01, 8'h00, mh);
      for (int k = 0; k < 40; k++) step_chain(2'b01, 1'b0);
      for (int k = 0; k < 12; k++) begin
        next_bit(b);
        step_chain(2'b10, b);
      end
    end
    chain = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule